// File: doc/BRIEF.md
# Charger Command Serial Port

This block is the slave side of a synchronous serial port that configures a battery charger controller. A host lowers an active-low select, then clocks bits in on a data input. The port skips every zero that arrives before the first one. That first one is the start bit, and the 21 bits after it form a command word. The command word selects the charger operating mode, the converter input channel and the battery divider ratio. Once the full word has arrived, it is written to a parallel register and a one-cycle conversion-start strobe is raised.

The return path can share one wire with the command path. After the 23rd falling serial clock edge that follows the start bit, the port takes over the line. It sends a low null bit, then the 10-bit conversion result with the most significant bit first, then the status word with the most significant bit first, and after that zeros. Raising the select at any point ends the frame, releases the line and sends the port back to searching for a start bit.

The serial clock, select and data input are treated as signals synchronous to the fast system clock `clk`. Each one is sampled once per system clock cycle. Serial clock edges are detected by comparing the current sample with the registered previous one. Each serial clock phase must therefore last at least two system clock cycles.

Top module: `chg_cmd_port`

## Requirements
- R1: After reset, dout_oe and dout are 0, conv_start is 0, cmd_word is all zeros and mode reads 0 (shutdown).
- R2: While cs_n is low and no start bit has yet been seen, din is sampled on each rising sclk edge. Samples of 0 are discarded. The first sample of 1 is the start bit and is not stored.
- R3: The 21 din samples that follow the start bit form cmd_word, with the first of them landing in bit 20 and the last in bit 0. On the system clock edge that detects the 21st of these rising edges, cmd_word updates and conv_start is high for exactly one clk cycle.
- R4: mode is decoded from cmd_word[20:18]. Codes 0 to 4 give 0 shutdown, 1 idle, 2 discharge, 3 charge and 4 gas gauge. Codes 5 to 7 give 0 (shutdown).
- R5: adc_sel equals cmd_word[15:13] and div_sel equals cmd_word[12:9].
- R6: dout_oe stays 0 until the 23rd falling sclk edge after the start bit and goes to 1 on that edge.
- R7: While dout_oe is 1, dout changes on falling sclk edges. It gives 0 at the takeover edge, then the result bits from bit 9 down to bit 0, then the status bits from the top bit down to bit 0, and 0 on every edge after that.
- R8: When cs_n is high, dout_oe is 0 in the same cycle. sclk and din activity while cs_n is high changes neither cmd_word nor conv_start.
- R9: If cs_n rises before all 21 command bits have arrived, cmd_word keeps its previous value and no conv_start pulse occurs.
- R10: din values clocked in after the 21st command bit in the same frame are ignored. Each frame produces at most one conv_start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial command data from the host |
| adc_result | input | RES_W (10) | Conversion result to return |
| status_in | input | STAT_W (8) | Status word to return |
| dout | output | 1 | Serial return data |
| dout_oe | output | 1 | Drive enable for dout on the shared wire |
| cmd_word | output | 21 | Last complete command word |
| mode | output | 3 | Decoded operating mode |
| adc_sel | output | 3 | Converter input select field |
| div_sel | output | 4 | Battery divider ratio field |
| conv_start | output | 1 | One-cycle conversion launch strobe |

## Verification
A bit counter that is off by one shows up in two ways within the same frame: cmd_word is shifted by one position, and dout_oe rises one serial period early or late. If the start-bit search treats leading zeros as data, the stored word is wrong as soon as the first frame that has leading zeros completes. A wrong abort path shows up on the next select rise, either as an enable that stays asserted or as a changed command register with no complete frame behind it. A wrong output shifter shows up as a wrong bit within a few serial periods after takeover.

// File: rtl/chg_cmd_pkg.sv
package chg_cmd_pkg;

    localparam int CMD_BITS = 21;
    localparam int MODE_HI  = 20;
    localparam int MODE_LO  = 18;
    localparam int SEL_HI   = 15;
    localparam int SEL_LO   = 13;
    localparam int DIV_HI   = 12;
    localparam int DIV_LO   = 9;

    typedef enum logic [2:0] {
        MODE_OFF   = 3'd0,
        MODE_IDLE  = 3'd1,
        MODE_DSCH  = 3'd2,
        MODE_CHRG  = 3'd3,
        MODE_GAUGE = 3'd4
    } op_mode_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_CMD,
        RX_DONE
    } rx_state_e;

    typedef struct packed {
        op_mode_e   mode;
        logic [2:0] sel;
        logic [3:0] div;
    } cmd_fields_t;

    function automatic op_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd1:    return MODE_IDLE;
            3'd2:    return MODE_DSCH;
            3'd3:    return MODE_CHRG;
            3'd4:    return MODE_GAUGE;
            default: return MODE_OFF;
        endcase
    endfunction

    function automatic cmd_fields_t split_cmd(input logic [CMD_BITS-1:0] w);
        cmd_fields_t f;
        f.mode = decode_mode(w[MODE_HI:MODE_LO]);
        f.sel  = w[SEL_HI:SEL_LO];
        f.div  = w[DIV_HI:DIV_LO];
        return f;
    endfunction

endpackage

// File: rtl/chg_sclk_edge.sv
module chg_sclk_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/chg_cmd_rx.sv
module chg_cmd_rx
    import chg_cmd_pkg::*;
#(
    parameter int NBITS = CMD_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rise,
    input  logic             din,
    output logic [NBITS-1:0] cmd_q,
    output logic             conv_start,
    output logic             in_frame
);
    localparam int CNT_W = $clog2(NBITS + 1);

    rx_state_e        state;
    logic [NBITS-1:0] shreg;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_HUNT;
            shreg      <= '0;
            cnt        <= '0;
            cmd_q      <= '0;
            conv_start <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            if (cs_n) begin
                state <= RX_HUNT;
                cnt   <= '0;
            end else if (rise) begin
                case (state)
                    RX_HUNT: begin
                        if (din) begin
                            state <= RX_CMD;
                            cnt   <= '0;
                        end
                    end
                    RX_CMD: begin
                        shreg <= {shreg[NBITS-2:0], din};
                        if (cnt == CNT_W'(NBITS - 1)) begin
                            cmd_q      <= {shreg[NBITS-2:0], din};
                            conv_start <= 1'b1;
                            state      <= RX_DONE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign in_frame = (state != RX_HUNT);
endmodule

// File: rtl/chg_dout_tx.sv
module chg_dout_tx #(
    parameter int TAKE   = 23,
    parameter int RES_W  = 10,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              in_frame,
    input  logic              fall,
    input  logic [RES_W-1:0]  result,
    input  logic [STAT_W-1:0] status,
    output logic              dout,
    output logic              dout_oe
);
    localparam int SH_W = 1 + RES_W + STAT_W;
    localparam int FC_W = $clog2(TAKE + 1);

    logic [FC_W-1:0] fcnt;
    logic [SH_W-1:0] sh;
    logic            oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt <= '0;
            sh   <= '0;
            oe_q <= 1'b0;
        end else if (cs_n || !in_frame) begin
            fcnt <= '0;
            sh   <= '0;
            oe_q <= 1'b0;
        end else if (fall) begin
            if (!oe_q) begin
                if (fcnt == FC_W'(TAKE - 1)) begin
                    oe_q <= 1'b1;
                    sh   <= {1'b0, result, status};
                end else begin
                    fcnt <= fcnt + 1'b1;
                end
            end else begin
                sh <= {sh[SH_W-2:0], 1'b0};
            end
        end
    end

    assign dout_oe = oe_q & ~cs_n;
    assign dout    = dout_oe & sh[SH_W-1];
endmodule

// File: rtl/chg_cmd_port.sv
module chg_cmd_port
    import chg_cmd_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int STAT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                din,
    input  logic [RES_W-1:0]    adc_result,
    input  logic [STAT_W-1:0]   status_in,
    output logic                dout,
    output logic                dout_oe,
    output logic [CMD_BITS-1:0] cmd_word,
    output logic [2:0]          mode,
    output logic [2:0]          adc_sel,
    output logic [3:0]          div_sel,
    output logic                conv_start
);
    localparam int TAKEOVER = CMD_BITS + 2;

    logic        rise, fall, in_frame;
    cmd_fields_t fields;

    chg_sclk_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    chg_cmd_rx #(.NBITS(CMD_BITS)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .rise       (rise),
        .din        (din),
        .cmd_q      (cmd_word),
        .conv_start (conv_start),
        .in_frame   (in_frame)
    );

    chg_dout_tx #(.TAKE(TAKEOVER), .RES_W(RES_W), .STAT_W(STAT_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .in_frame (in_frame),
        .fall     (fall),
        .result   (adc_result),
        .status   (status_in),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    assign fields  = split_cmd(cmd_word);
    assign mode    = fields.mode;
    assign adc_sel = fields.sel;
    assign div_sel = fields.div;
endmodule

// File: rtl/chg_cmd_port_chk.sv
module chg_cmd_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        cs_n,
    input logic        sclk,
    input logic        dout_oe,
    input logic        conv_start,
    input logic [2:0]  mode,
    input logic [20:0] cmd_word
);
    // R3
    conv_single_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R4
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mode <= 3'd4);

    // R6
    oe_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_oe) |-> (!$past(sclk) && $past(sclk, 2)));

    // R8
    cs_release_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !dout_oe);

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmd_word) |-> conv_start);

    // R9
    conv_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !$past(cs_n));
endmodule

bind chg_cmd_port chg_cmd_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .dout_oe    (dout_oe),
    .conv_start (conv_start),
    .mode       (mode),
    .cmd_word   (cmd_word)
);

// File: tb/chg_cmd_port_tb.sv
module chg_cmd_port_tb;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [9:0]  adc_result = '0;
    logic [7:0]  status_in = '0;
    logic        dout, dout_oe, conv_start;
    logic [20:0] cmd_word;
    logic [2:0]  mode, adc_sel;
    logic [3:0]  div_sel;

    int total = 0;
    int bad = 0;
    int conv_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    chg_cmd_port u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .adc_result(adc_result), .status_in(status_in),
        .dout(dout), .dout_oe(dout_oe), .cmd_word(cmd_word),
        .mode(mode), .adc_sel(adc_sel), .div_sel(div_sel),
        .conv_start(conv_start)
    );

    always @(posedge clk) if (!rst && conv_start) conv_cnt++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [20:0] make_cmd(input logic [2:0] m, input logic [2:0] s,
                                             input logic [3:0] d, input logic [7:0] extra);
        logic [20:0] w;
        w        = '0;
        w[20:18] = m;
        w[17:16] = extra[1:0];
        w[15:13] = s;
        w[12:9]  = d;
        w[8:1]   = extra;
        w[0]     = extra[7];
        return w;
    endfunction

    task automatic sbit(input logic b);
        din  = b;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic end_frame();
        cs_n = 1'b1;
        din  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_cmd(input int nzero, input logic [20:0] w, input string tag);
        int oe_early = 0;
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nzero; i++) sbit(1'b0);
        sbit(1'b1);
        for (int i = 20; i >= 0; i--) begin
            sbit(w[i]);
            if (dout_oe) oe_early++;
        end
        check({tag, " R6 oe low before takeover"}, oe_early, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 dout_oe", dout_oe, 0);
        check("R1 dout", dout, 0);
        check("R1 cmd_word", cmd_word, 0);
        check("R1 mode", mode, 0);
        check("R1 conv_start", conv_start, 0);
    endtask

    task automatic t_frame(input int nzero, input logic [20:0] w, input logic [2:0] exp_mode,
                           input logic [9:0] res, input logic [7:0] st, input string tag);
        int c0 = conv_cnt;
        logic exp_bit;
        adc_result = res;
        status_in  = st;
        @(negedge clk);
        send_cmd(nzero, w, tag);
        check({tag, " R2 R3 cmd_word"}, cmd_word, w);
        check({tag, " R3 one conv_start"}, conv_cnt - c0, 1);
        check({tag, " R4 mode"}, mode, exp_mode);
        check({tag, " R5 adc_sel"}, adc_sel, w[15:13]);
        check({tag, " R5 div_sel"}, div_sel, w[12:9]);
        for (int j = 0; j < 22; j++) begin
            sbit(1'b1);
            if (j == 0)       exp_bit = 1'b0;
            else if (j <= 10) exp_bit = res[10 - j];
            else if (j <= 18) exp_bit = st[18 - j];
            else              exp_bit = 1'b0;
            check({tag, " R6 dout_oe"}, dout_oe, 1);
            check({tag, $sformatf(" R7 dout bit %0d", j)}, dout, exp_bit);
        end
        check({tag, " R10 cmd_word after trailing ones"}, cmd_word, w);
        check({tag, " R10 single conv_start"}, conv_cnt - c0, 1);
        end_frame();
        check({tag, " R8 oe after cs high"}, dout_oe, 0);
    endtask

    task automatic t_abort_cmd();
        logic [20:0] prev = cmd_word;
        int c0 = conv_cnt;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        sbit(1'b1);
        for (int i = 0; i < 12; i++) sbit(i[0]);
        end_frame();
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 9; i++) sbit(1'b1);
        end_frame();
        check("R9 cmd_word kept after abort", cmd_word, prev);
        check("R9 no conv_start after abort", conv_cnt - c0, 0);
    endtask

    task automatic t_abort_data();
        logic [20:0] w = make_cmd(3'd2, 3'd1, 4'd3, 8'h11);
        @(negedge clk);
        send_cmd(0, w, "abort_data");
        sbit(1'b0);
        sbit(1'b0);
        check("R6 oe on in data phase", dout_oe, 1);
        cs_n = 1'b1;
        @(negedge clk);
        check("R8 oe drops with cs_n", dout_oe, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_cs_high_ignored();
        logic [20:0] prev = cmd_word;
        int c0 = conv_cnt;
        int oe_seen = 0;
        @(negedge clk);
        cs_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            sbit(1'b1);
            if (dout_oe) oe_seen++;
        end
        check("R8 no oe while deselected", oe_seen, 0);
        check("R8 cmd_word untouched while deselected", cmd_word, prev);
        check("R8 no conv_start while deselected", conv_cnt - c0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_frame(3, make_cmd(3'd3, 3'd5, 4'b1011, 8'hA5), 3'd3, 10'h2D9, 8'hC3, "charge");
        t_frame(0, make_cmd(3'd4, 3'd2, 4'b0110, 8'h3C), 3'd4, 10'h155, 8'h81, "gauge");
        t_frame(1, make_cmd(3'd6, 3'd7, 4'b1111, 8'h00), 3'd0, 10'h3FF, 8'h7E, "badmode");
        t_frame(5, make_cmd(3'd1, 3'd0, 4'b0001, 8'hFF), 3'd1, 10'h200, 8'h01, "idle");
        t_abort_cmd();
        t_abort_data();
        t_cs_high_ignored();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule